// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets synchronous logic reach an external 128K x 8 asynchronous static RAM. A client places one read or one write on a valid/ready request port. The sequencer latches the request, then drives the RAM's address, two chip selects of opposite polarity, write strobe and output strobe in a fixed order. It counts system clocks so that each minimum timing window of the memory is met. Read data is registered and returned with a one-cycle response strobe. A write ends with a one-cycle completion strobe.

The RAM shares one bidirectional data bus for reads and writes. The block does not contain a pad, so it presents the tri-state driver as a separate output value, a driver enable and an input value. It controls the driver enable and keeps it off until the RAM's outputs have had time to float after a read. Every timing limit is a parameter in picoseconds. Together with the clock period parameter, each limit is rounded up to a whole number of clock cycles when the block is elaborated.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the select lines are inactive (sram_cs1_n = 1, sram_cs2 = 0), sram_we_n = 1, sram_oe_n = 1, sram_dq_oe = 0, rsp_valid = 0, wr_done = 0 and req_ready = 1.
- R2: The RAM is selected only during an accepted access. Selection means sram_cs1_n low together with sram_cs2 high. While no request is pending, both select lines stay inactive.
- R3: A read holds sram_oe_n low with sram_we_n high for RD_CYC cycles, where RD_CYC = max(ceil(tAA/Tclk), ceil(tRC/Tclk), ceil(tOE/Tclk)), with a minimum of 1. It registers sram_dq_i on the last of these cycles. rsp_valid is high for exactly one cycle, RD_CYC cycles after the accepting edge, and carries the data on rsp_rdata.
- R4: During a write pulse (sram_we_n low), the RAM is selected, sram_oe_n is high and sram_dq_oe is high with sram_dq_o equal to the request's data.
- R5: sram_addr is loaded only when a request is accepted and does not change while the RAM is selected. Request inputs that change during an access have no effect on that access.
- R6: sram_dq_oe never rises fewer than HZ_CYC = ceil(tHZ/Tclk) cycles after sram_oe_n rises, and it is low whenever sram_oe_n is low.
- R7: req_ready is low from the accepting edge until the access completes, so only one access is outstanding at a time. wr_done is high for exactly one cycle per write.
- R8: The write pulse lasts WP_CYC cycles, where WP_CYC = max(ceil(tWP/Tclk), ceil(tDW/Tclk), ceil(tCW/Tclk)-1, ceil(tWC/Tclk)-1, 1). It is preceded by at least one cycle in which the RAM is selected with both strobes high.
- R9: A write accepted while the bus is still floating waits in its select phase until HZ_CYC cycles have passed since sram_oe_n rose. A write on an idle bus reaches wr_done WP_CYC+1 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle strobe: read data valid |
| rsp_rdata | output | 8 | Read data |
| wr_done | output | 1 | One-cycle strobe: write finished |
| sram_addr | output | 17 | RAM address pins |
| sram_cs1_n | output | 1 | RAM select, active low |
| sram_cs2 | output | 1 | RAM select, active high |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output strobe, active low |
| sram_dq_o | output | 8 | Value for the data pad driver |
| sram_dq_oe | output | 1 | Data pad driver enable |
| sram_dq_i | input | 8 | Value seen on the data pads |

## Verification
The hardest case to reach is a write that arrives while the RAM is still releasing the bus after a read. With the default float time this window is already over by the time a new request can be accepted. The bench therefore builds the block with a longer float parameter, so that back-to-back read-then-write pairs enter the wait. A RAM model in the bench treats the bus as busy for that many cycles after the output strobe rises. The model only returns valid data once the access window has elapsed, so early sampling and early driver turn-on both show up as wrong data or contention.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_END   = 3'd2,
    ST_WR_SEL   = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_END   = 3'd5
  } sram_phase_e;

  // Round a time in picoseconds up to whole clock cycles, never below one.
  function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sram_float_timer.sv
// Counts down the time the RAM needs to release the shared bus.
module sram_float_timer #(
  parameter int HZ_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic clear
);
  import sram_ctrl_pkg::*;

  localparam int FW = cnt_bits(HZ_CYC);

  logic [FW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= FW'(HZ_CYC);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign clear = (remain == '0);

endmodule

// File: rtl/sram_dq_path.sv
// Address and write data holding registers plus the read capture register.
module sram_dq_path #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= dq_i;
    end
  end

endmodule

// File: rtl/sram_seq.sv
// Phase sequencer: all pin strobes are registered from the next phase.
module sram_seq #(
  parameter int RD_CYC = 3,
  parameter int WP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic bus_clear,
  output logic req_ready,
  output logic accept,
  output logic cap_en,
  output logic sel_q,
  output logic oe_n_q,
  output logic we_n_q,
  output logic drv_q,
  output logic rsp_q,
  output logic done_q
);
  import sram_ctrl_pkg::*;

  localparam int CNT_W = cnt_bits(imax(RD_CYC, WP_CYC));

  sram_phase_e      st, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign accept = (st == ST_IDLE) && req_valid;
  assign cap_en = (st == ST_RD_ACC) && (cnt == '0);

  always_comb begin
    nxt     = st;
    cnt_nxt = cnt;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            nxt = ST_WR_SEL;
          end else begin
            nxt     = ST_RD_ACC;
            cnt_nxt = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD_ACC: begin
        if (cnt == '0) nxt = ST_RD_END;
        else           cnt_nxt = cnt - 1'b1;
      end
      ST_RD_END: nxt = ST_IDLE;
      ST_WR_SEL: begin
        if (bus_clear) begin
          nxt     = ST_WR_PULSE;
          cnt_nxt = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WR_PULSE: begin
        if (cnt == '0) nxt = ST_WR_END;
        else           cnt_nxt = cnt - 1'b1;
      end
      ST_WR_END: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sel_q     <= 1'b0;
      oe_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      drv_q     <= 1'b0;
      rsp_q     <= 1'b0;
      done_q    <= 1'b0;
      req_ready <= 1'b1;
    end else begin
      st        <= nxt;
      cnt       <= cnt_nxt;
      sel_q     <= (nxt == ST_RD_ACC) || (nxt == ST_WR_SEL) || (nxt == ST_WR_PULSE);
      oe_n_q    <= (nxt != ST_RD_ACC);
      we_n_q    <= (nxt != ST_WR_PULSE);
      drv_q     <= (nxt == ST_WR_PULSE) || (nxt == ST_WR_END);
      rsp_q     <= (nxt == ST_RD_END);
      done_q    <= (nxt == ST_WR_END);
      req_ready <= (nxt == ST_IDLE);
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CLK_PS  = 5000,
  parameter int T_RC_PS = 15000,
  parameter int T_AA_PS = 15000,
  parameter int T_OE_PS = 8000,
  parameter int T_WC_PS = 15000,
  parameter int T_CW_PS = 10000,
  parameter int T_WP_PS = 10000,
  parameter int T_DW_PS = 7000,
  parameter int T_HZ_PS = 8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_done,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs1_n,
  output logic              sram_cs2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  import sram_ctrl_pkg::*;

  localparam int RD_CYC = imax(imax(ps_to_cyc(T_AA_PS, CLK_PS), ps_to_cyc(T_RC_PS, CLK_PS)),
                               ps_to_cyc(T_OE_PS, CLK_PS));
  // Select is already active one cycle before the pulse, so chip-select and
  // cycle-time windows need one cycle less inside the pulse itself.
  localparam int WP_CYC = imax(imax(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_DW_PS, CLK_PS)),
                               imax(imax(ps_to_cyc(T_CW_PS, CLK_PS) - 1,
                                         ps_to_cyc(T_WC_PS, CLK_PS) - 1), 1));
  localparam int HZ_CYC = ps_to_cyc(T_HZ_PS, CLK_PS);

  logic accept, cap_en, bus_clear;
  logic sel_q, drv_q;

  sram_seq #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .bus_clear (bus_clear),
    .req_ready (req_ready),
    .accept    (accept),
    .cap_en    (cap_en),
    .sel_q     (sel_q),
    .oe_n_q    (sram_oe_n),
    .we_n_q    (sram_we_n),
    .drv_q     (drv_q),
    .rsp_q     (rsp_valid),
    .done_q    (wr_done)
  );

  sram_float_timer #(
    .HZ_CYC (HZ_CYC)
  ) u_float (
    .clk   (clk),
    .rst   (rst),
    .load  (cap_en),
    .clear (bus_clear)
  );

  sram_dq_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .cap_en    (cap_en),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_i      (sram_dq_i),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dq_o),
    .rdata_q   (rsp_rdata)
  );

  assign sram_cs1_n = ~sel_q;
  assign sram_cs2   = sel_q;
  assign sram_dq_oe = drv_q;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int HZ_CYC = 2,
  parameter int WP_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              wr_done,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_cs1_n,
  input logic              sram_cs2,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);
  logic [15:0] oe_age;
  logic [15:0] we_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_age <= 16'hFFFF;
      we_len <= '0;
    end else begin
      if (!sram_oe_n)             oe_age <= '0;
      else if (oe_age != 16'hFFFF) oe_age <= oe_age + 1'b1;
      if (sram_we_n) we_len <= '0;
      else           we_len <= we_len + 1'b1;
    end
  end

  AST_OE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (!sram_cs1_n && sram_cs2 && sram_we_n)); // R3
  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_cs1_n && sram_cs2)); // R4
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_oe_n && sram_dq_oe)); // R4
  AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !sram_dq_oe); // R6
  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (oe_age >= 16'(HZ_CYC))); // R6
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_len == 16'(WP_CYC))); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs1_n && $past(!sram_cs1_n)) |-> $stable(sram_addr)); // R5
  AST_RSP_ONE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R3
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wr_done); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !sram_cs1_n |-> !req_ready); // R7

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .HZ_CYC (HZ_CYC),
  .WP_CYC (WP_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .wr_done    (wr_done),
  .sram_addr  (sram_addr),
  .sram_cs1_n (sram_cs1_n),
  .sram_cs2   (sram_cs2),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
  // Bench timing at 5 ns: read window 3, write pulse 2, float window 4 (20 ns).
  localparam int RD_LAT = 3;
  localparam int WP_LEN = 2;
  localparam int HZ_LEN = 4;
  localparam int WR_LAT_IDLE = 1 + WP_LEN;
  // Task spacing puts acceptance 3 edges after the read's output strobe rises.
  localparam int WR_LAT_RD = (((HZ_LEN - 2) > 1) ? (HZ_LEN - 2) : 1) + WP_LEN;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        wr_done;
  logic [16:0] sram_addr;
  logic        sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_o;
  logic [7:0]  sram_dq_i = 8'hE7;

  always #2.5 clk = ~clk;

  sram_async_ctrl #(.T_HZ_PS(20000)) u_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_done(wr_done),
    .sram_addr(sram_addr), .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [7:0] mem [logic [16:0]];
  function automatic logic [7:0] mem_rd(input logic [16:0] a);
    return mem.exists(a) ? mem[a] : (a[7:0] ^ 8'h5A);
  endfunction

  int          vcnt = 0;
  bit          drv_prev = 0;
  logic [16:0] addr_prev = '0;
  int          tail = 0;
  int          we_len = 0;
  bit          pulse_bad = 0;
  logic [7:0]  pend_d = '0;
  bit          oe_oe_prev = 0;
  bit          addr_bad = 0;
  bit          sel_prev = 0;
  logic [16:0] addr_held = '0;

  always @(negedge clk) begin
    bit sel, ram_drv;
    sel     = !sram_cs1_n && sram_cs2;
    ram_drv = sel && !sram_oe_n && sram_we_n;
    if (!rst) begin
      // read data appears only after the full access window
      if (ram_drv) begin
        vcnt = (drv_prev && sram_addr == addr_prev) ? vcnt + 1 : 0;
        sram_dq_i = (vcnt >= RD_LAT - 1) ? mem_rd(sram_addr) : 8'hE7;
      end else begin
        vcnt = 0;
        sram_dq_i = 8'hE7;
      end
      if (ram_drv) tail = HZ_LEN + 1;
      else if (tail > 0) tail--;
      // R6: driver turn-on only after the RAM released the bus
      if (sram_dq_oe && !oe_oe_prev)
        chk(!ram_drv && tail == 0, "R6 driver on while RAM may drive", tail, 0);
      // R4/R8: write pulse shape, committed at end of write
      if (!sram_we_n) begin
        we_len++;
        if (!(sel && sram_oe_n && sram_dq_oe)) pulse_bad = 1;
        pend_d = sram_dq_o;
      end else if (we_len > 0) begin
        chk(!pulse_bad, "R4 strobes during write pulse", pulse_bad, 0);
        chk(we_len == WP_LEN, "R8 write pulse length", we_len, WP_LEN);
        mem[sram_addr] = pend_d;
        we_len = 0;
        pulse_bad = 0;
      end
      // R5 address stability while selected
      if (sel && sel_prev && sram_addr != addr_held) addr_bad = 1;
      addr_held = sram_addr;
      sel_prev  = sel;
      drv_prev  = ram_drv;
      addr_prev = sram_addr;
      oe_oe_prev = sram_dq_oe;
    end
  end

  // ---------------- request driver ----------------
  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // disturb the request port mid-access (R5)
    req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
    chk(!req_ready, "R7 ready low while busy", req_ready, 0);
    chk(!sram_cs1_n && sram_cs2, "R2 select polarity during access",
        {sram_cs1_n, sram_cs2}, 2'b01);
    if (!wr) chk(!sram_oe_n && sram_we_n && !sram_dq_oe, "R3 read strobes",
                 {sram_oe_n, sram_we_n, sram_dq_oe}, 3'b010);
    lat = 0;
    while (!(wr ? wr_done : rsp_valid) && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    @(negedge clk);
    if (wr) chk(!wr_done, "R7 done is one cycle", wr_done, 0);
    else    chk(!rsp_valid, "R3 response is one cycle", rsp_valid, 0);
    chk(!addr_bad, "R5 address stable in access", addr_bad, 0);
    addr_bad = 0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [16:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 17'h00000, 8'h3C},
    '{1'b1, 17'h1FFFF, 8'h81},
    '{1'b0, 17'h00000, 8'h3C},
    '{1'b0, 17'h1FFFF, 8'h81},
    '{1'b1, 17'h0AAAA, 8'h55},
    '{1'b0, 17'h0AAAA, 8'h55},
    '{1'b1, 17'h00000, 8'hC3},
    '{1'b0, 17'h00000, 8'hC3},
    '{1'b0, 17'h15555, 8'h0F},
    '{1'b1, 17'h15555, 8'hF0},
    '{1'b0, 17'h15555, 8'hF0},
    '{1'b0, 17'h1FFFF, 8'h81}
  };

  initial begin
    logic [7:0] rd;
    int lat;
    bit prev_rd;
    repeat (4) @(negedge clk);
    // R1 reset state while reset is held
    chk(sram_cs1_n && !sram_cs2 && sram_we_n && sram_oe_n && !sram_dq_oe,
        "R1 strobes in reset", {sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);
    chk(!rsp_valid && !wr_done && req_ready, "R1 handshake in reset",
        {rsp_valid, wr_done, req_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);
    chk(sram_cs1_n && !sram_cs2 && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready,
        "R1 first cycle after reset", {sram_cs1_n, sram_cs2, req_ready}, 3'b101);
    // R2: idle with no request leaves the RAM deselected
    repeat (5) @(negedge clk);
    chk(sram_cs1_n && !sram_cs2, "R2 idle deselected", {sram_cs1_n, sram_cs2}, 2'b10);

    prev_rd = 0;
    foreach (VECS[i]) begin
      do_op(VECS[i].wr, VECS[i].a, VECS[i].d, rd, lat);
      if (VECS[i].wr) begin
        chk(lat == (prev_rd ? WR_LAT_RD : WR_LAT_IDLE),
            prev_rd ? "R9 write latency after read" : "R8 write latency on idle bus",
            lat, prev_rd ? WR_LAT_RD : WR_LAT_IDLE);
      end else begin
        chk(lat == RD_LAT, "R3 read latency", lat, RD_LAT);
        chk(rd == VECS[i].d, "R3 read data", rd, VECS[i].d);
      end
      prev_rd = !VECS[i].wr;
    end

    // directed: write after an idle gap following a read takes the short path (R9)
    do_op(1'b0, 17'h00123, 8'h00, rd, lat);
    chk(rd == (8'h23 ^ 8'h5A), "R3 read of untouched location", rd, 8'h23 ^ 8'h5A);
    repeat (HZ_LEN + 2) @(negedge clk);
    do_op(1'b1, 17'h00123, 8'hA7, rd, lat);
    chk(lat == WR_LAT_IDLE, "R9 no wait once bus floated", lat, WR_LAT_IDLE);
    do_op(1'b0, 17'h00123, 8'h00, rd, lat);
    chk(rd == 8'hA7, "R4 written data reaches RAM", rd, 8'hA7);
    chk(mem_rd(17'h00123) == 8'hA7, "R4 RAM content", mem_rd(17'h00123), 8'hA7);

    // directed: reset in the middle of a write returns to the idle pin state (R1)
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00777; req_wdata = 8'h11;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sram_cs1_n && !sram_cs2 && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready,
        "R1 state after mid-write reset", {sram_cs1_n, sram_we_n, sram_dq_oe}, 3'b110);
    we_len = 0; pulse_bad = 0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule